// File: doc/BRIEF.md
# Multiplexed Settling-Aware Channel Sequencer

This block scans a set of analog input channels that share a single modulator and decimation filter. Each time it moves the input multiplexer to a new channel, it pulses the filter reset. It then counts filter data-ready events and throws away every output that still depends on modulator samples taken before the switch. The first output that rests only on samples from the new channel is kept, marked with its channel index, and presented with a one-cycle valid strobe. The sequencer then moves on to the next enabled channel.

How many filter outputs must pass depends on the filter. For a plain sinc filter of order P, the settling time is P output periods. A fifth-order stage followed by an N-sample averager settles after 5 + (N − 1) fifth-order periods. Counted in averaged output periods, that is 1 + ceil(4/N) outputs. The filter type and averaging count are read at every switch, so each channel's wait matches the filter setup that was in force when its conversion began.

Channels are visited in ascending order and the scan wraps back to the lowest enabled channel. When only one channel is enabled, the sequencer stays on it and passes through every output once the filter has settled. An all-zero mask parks the block with the filter held in reset.

Top module: `mux_settle_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sel_o` is 0, `flt_rst_o` is 1 and `res_vld_o` is 0.
- R2: While `en_mask_i` is all zeros, `flt_rst_o` stays high from the next cycle on, and no result is presented, even if data-ready pulses arrive.
- R3: Filter mode encoding is 2'b00 third-order sinc, 2'b01 fifth-order sinc and 2'b11 first-order averager. After a switch, the sequencer accepts data-ready number 3, 5 or 1 respectively.
- R4: Mode 2'b10 is a fifth-order stage followed by an N-sample averager, with N = `avg_cnt_i` and 0 treated as 1. The sequencer accepts data-ready number 1 + ceil(4/N): 5 for N=1, 3 for N=2 or 3, and 2 for N≥4.
- R5: When data-ready is accepted on a clock edge, `res_vld_o` is high for the following cycle, with `res_o` equal to the filter data and `res_ch_o` equal to the channel. Discarded outputs never raise `res_vld_o`.
- R6: After a result, the next selected channel is the lowest enabled index above the current one. If there is none, it is the lowest enabled index.
- R7: `sel_o` changes only in a cycle in which `flt_rst_o` is high. On a channel switch, `flt_rst_o` is high for exactly that one cycle. A data-ready during that cycle is not counted.
- R8: With exactly one channel enabled, the selection stays put, no further filter reset occurs, and every data-ready after the first accepted one produces a result.
- R9: Filter mode and averaging count are captured at the switch. Changing them while a channel settles does not change that channel's wait.
- R10: If the selected channel is removed from the mask, the sequencer switches to the next enabled channel in the next cycle, with a filter reset and no result.
- R11: When the mask leaves all-zeros, the lowest enabled channel is selected, with a filter reset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_mask_i | input | NUM_CH | One bit per channel, 1 = include in scan |
| flt_mode_i | input | 2 | Filter type selector (see R3, R4) |
| avg_cnt_i | input | AVG_W | Averaging count N for the two-stage mode |
| drdy_i | input | 1 | Filter data-ready, one cycle per output |
| flt_data_i | input | DATA_W | Filter output word, valid with `drdy_i` |
| sel_o | output | CH_W | Multiplexer channel select |
| flt_rst_o | output | 1 | Filter reset |
| res_vld_o | output | 1 | One-cycle strobe for a settled result |
| res_ch_o | output | CH_W | Channel index of the result |
| res_o | output | DATA_W | Settled result word |

## Verification
The bench uses the default build: four channels, 24-bit data and an 8-bit averaging count. With four channels, a full scan runs in each filter mode, including wrap-around from channel 3 back to a lower index. The 8-bit count reaches every branch of the 1 + ceil(4/N) rule, including N=0, N=1 and large N. Directed runs cover single-channel pass-through, mode changes during settling, removal of the selected channel, data-ready arriving inside the reset cycle, and an all-zero mask in the middle of a scan.

// File: rtl/mss_pkg.sv
package mss_pkg;

    // filter selector codes seen on the flt_mode_i port
    typedef enum logic [1:0] {
        FLT_SINC3 = 2'b00,
        FLT_SINC5 = 2'b01,
        FLT_S5AVG = 2'b10,
        FLT_SINC1 = 2'b11
    } flt_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } seq_st_e;

    // settle counter must hold the largest accept index (5)
    localparam int CNT_W = 3;

endpackage

// File: rtl/mss_settle_target.sv
// Number of the filter output, counted from 1 after a switch, that is the
// first one built purely from post-switch modulator samples.
module mss_settle_target
    import mss_pkg::*;
#(
    parameter int AVG_W = 8
) (
    input  flt_mode_e              mode_i,
    input  logic [AVG_W-1:0]       avg_i,
    output logic [CNT_W-1:0]       tgt_o
);

    localparam logic [AVG_W-1:0] AVG_ONE   = AVG_W'(1);
    localparam logic [AVG_W-1:0] AVG_THREE = AVG_W'(3);

    always_comb begin
        unique case (mode_i)
            FLT_SINC3: tgt_o = CNT_W'(3);
            FLT_SINC5: tgt_o = CNT_W'(5);
            FLT_SINC1: tgt_o = CNT_W'(1);
            default: begin
                // 5 + (N-1) fifth-order periods = 1 + ceil(4/N) averaged outputs
                if (avg_i <= AVG_ONE) begin
                    tgt_o = CNT_W'(5);
                end else if (avg_i <= AVG_THREE) begin
                    tgt_o = CNT_W'(3);
                end else begin
                    tgt_o = CNT_W'(2);
                end
            end
        endcase
    end

endmodule

// File: rtl/mss_rr_pick.sv
// Round-robin channel picker: lowest enabled index above cur_i, wrapping
// to the lowest enabled index overall.
module mss_rr_pick #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [CH_W-1:0]   cur_i,
    output logic [CH_W-1:0]   next_o,
    output logic [CH_W-1:0]   low_o
);

    logic [NUM_CH-1:0] above;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_above
        localparam logic [CH_W-1:0] IDX = CH_W'(g);
        assign above[g] = mask_i[g] && (IDX > cur_i);
    end

    logic [CH_W-1:0] nxt_above;
    logic            hit_above;

    always_comb begin
        low_o     = '0;
        nxt_above = '0;
        hit_above = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                low_o = CH_W'(i);
            end
            if (above[i]) begin
                nxt_above = CH_W'(i);
                hit_above = 1'b1;
            end
        end
        next_o = hit_above ? nxt_above : low_o;
    end

endmodule

// File: rtl/mux_settle_seq.sv
module mux_settle_seq
    import mss_pkg::*;
#(
    parameter int  NUM_CH = 4,
    parameter int  DATA_W = 24,
    parameter int  AVG_W  = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] en_mask_i,
    input  logic [1:0]        flt_mode_i,
    input  logic [AVG_W-1:0]  avg_cnt_i,
    input  logic              drdy_i,
    input  logic [DATA_W-1:0] flt_data_i,
    output logic [CH_W-1:0]   sel_o,
    output logic              flt_rst_o,
    output logic              res_vld_o,
    output logic [CH_W-1:0]   res_ch_o,
    output logic [DATA_W-1:0] res_o
);

    typedef struct packed {
        seq_st_e           st;
        logic [CH_W-1:0]   sel;
        logic              frst;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  tgt;
        logic              vld;
        logic [CH_W-1:0]   tag;
        logic [DATA_W-1:0] res;
    } seq_s;

    seq_s q, d;

    logic [CNT_W-1:0] tgt_now;
    logic [CH_W-1:0]  ch_next;
    logic [CH_W-1:0]  ch_low;
    logic [CNT_W-1:0] cnt_inc;

    mss_settle_target #(.AVG_W(AVG_W)) u_tgt (
        .mode_i (flt_mode_e'(flt_mode_i)),
        .avg_i  (avg_cnt_i),
        .tgt_o  (tgt_now)
    );

    mss_rr_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .mask_i (en_mask_i),
        .cur_i  (q.sel),
        .next_o (ch_next),
        .low_o  (ch_low)
    );

    assign cnt_inc = q.cnt + CNT_W'(1);

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.frst = 1'b0;
        if (en_mask_i == '0) begin
            // nothing to scan: park with the filter held in reset
            d.st   = ST_IDLE;
            d.frst = 1'b1;
            d.cnt  = '0;
        end else if (q.st == ST_IDLE) begin
            d.st   = ST_SETTLE;
            d.sel  = ch_low;
            d.frst = 1'b1;
            d.cnt  = '0;
            d.tgt  = tgt_now;
        end else if (!en_mask_i[q.sel]) begin
            // selected channel withdrawn: abandon it without a result
            d.sel  = ch_next;
            d.frst = 1'b1;
            d.cnt  = '0;
            d.tgt  = tgt_now;
        end else if (drdy_i && !q.frst) begin
            if (cnt_inc >= q.tgt) begin
                d.vld = 1'b1;
                d.tag = q.sel;
                d.res = flt_data_i;
                if (ch_next != q.sel) begin
                    d.sel  = ch_next;
                    d.frst = 1'b1;
                    d.cnt  = '0;
                    d.tgt  = tgt_now;
                end
            end else begin
                d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.frst <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sel_o     = q.sel;
    assign flt_rst_o = q.frst;
    assign res_vld_o = q.vld;
    assign res_ch_o  = q.tag;
    assign res_o     = q.res;

endmodule

// File: rtl/mss_chk.sv
module mss_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] en_mask_i,
    input logic              drdy_i,
    input logic [CH_W-1:0]   sel_o,
    input logic              flt_rst_o,
    input logic              res_vld_o
);

    // R7: the multiplexer never moves without a filter reset
    a_r7_sel_move_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o != $past(sel_o)) |-> flt_rst_o);

    // R2: an empty mask holds the filter in reset
    a_r2_idle_holds_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_mask_i == '0) |=> flt_rst_o);

    // R2: an empty mask yields no result
    a_r2_idle_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_mask_i == '0) |=> !res_vld_o);

    // R5: every result comes from a data-ready seen outside the reset cycle
    a_r5_vld_from_drdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_vld_o |-> ($past(drdy_i) && !$past(flt_rst_o)));

endmodule

bind mux_settle_seq mss_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_mask_i (en_mask_i),
    .drdy_i    (drdy_i),
    .sel_o     (sel_o),
    .flt_rst_o (flt_rst_o),
    .res_vld_o (res_vld_o)
);

// File: tb/sim_mux_settle_seq.sv
`timescale 1ns/1ps
module sim_mux_settle_seq;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mask = '0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  avg = '0;
    logic        drdy = 1'b0;
    logic [23:0] data = '0;
    logic [1:0]  sel;
    logic        frst;
    logic        vld;
    logic [1:0]  tag;
    logic [23:0] res;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // sampled right after a data-ready was taken
    logic        s_vld, s_rst;
    logic [1:0]  s_tag, s_sel;
    logic [23:0] s_res;

    always #2.5 clk = ~clk;

    mux_settle_seq u0 (
        .clk_i(clk), .rst_ni(rst_n), .en_mask_i(mask), .flt_mode_i(mode),
        .avg_cnt_i(avg), .drdy_i(drdy), .flt_data_i(data), .sel_o(sel),
        .flt_rst_o(frst), .res_vld_o(vld), .res_ch_o(tag), .res_o(res)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] avg;
        logic [3:0] mask;
        logic [2:0] nacc;   // expected accept index after a switch
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'd0,   4'b1111, 3'd3},  // R3 third order
        '{2'b10, 8'd4,   4'b1111, 3'd2},  // R4 N=4
        '{2'b01, 8'd0,   4'b1010, 3'd5},  // R3 fifth order
        '{2'b11, 8'd0,   4'b0101, 3'd1},  // R3 averager only
        '{2'b10, 8'd1,   4'b0110, 3'd5},  // R4 N=1
        '{2'b10, 8'd2,   4'b1001, 3'd3},  // R4 N=2
        '{2'b10, 8'd3,   4'b1100, 3'd3},  // R4 N=3
        '{2'b10, 8'd0,   4'b0011, 3'd5},  // R4 N=0 acts as 1
        '{2'b10, 8'd200, 4'b1011, 3'd2}   // R4 large N
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] lowest(input logic [3:0] m);
        for (int c = NCH - 1; c >= 0; c--) if (m[c]) lowest = 2'(c);
    endfunction

    function automatic logic [1:0] next_en(input logic [3:0] m, input logic [1:0] cur);
        next_en = cur;
        for (int off = NCH - 1; off >= 1; off--) begin
            if (m[(int'(cur) + off) % NCH]) next_en = 2'((int'(cur) + off) % NCH);
        end
    endfunction

    // called at a negedge; returns at a negedge one idle cycle later
    task automatic pulse(input logic [23:0] dv);
        drdy = 1'b1; data = dv;
        @(negedge clk);
        drdy = 1'b0;
        s_vld = vld; s_tag = tag; s_res = res; s_sel = sel; s_rst = frst;
        @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] md, input logic [7:0] av, input logic [3:0] m);
        mask = '0;
        @(negedge clk);
        mode = md; avg = av; mask = m;
        @(negedge clk);
        chk("R11", {30'd0, sel}, {30'd0, lowest(m)});
        chk("R11", {31'd0, frst}, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] ch;
        logic [23:0] dv;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", {30'd0, sel}, 32'd0);
        chk("R1", {31'd0, frst}, 32'd1);
        chk("R1", {31'd0, vld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'd0, frst}, 32'd1);
        chk("R2", {31'd0, vld}, 32'd0);

        // table-driven scans
        for (int vi = 0; vi < NV; vi++) begin
            restart(VECS[vi].mode, VECS[vi].avg, VECS[vi].mask);
            ch = lowest(VECS[vi].mask);
            for (int st = 0; st <= $countones(VECS[vi].mask); st++) begin
                chk("R6", {30'd0, sel}, {30'd0, ch});
                chk("R7", {31'd0, frst}, 32'd0);
                for (int k = 1; k <= int'(VECS[vi].nacc); k++) begin
                    dv = {8'(vi), 8'(ch), 8'(k)};
                    pulse(dv);
                    if (k < int'(VECS[vi].nacc)) begin
                        chk("R5 discard", {31'd0, s_vld}, 32'd0);
                    end else begin
                        chk("R3/R4 accept", {31'd0, s_vld}, 32'd1);
                        chk("R5 data", {8'd0, s_res}, {8'd0, dv});
                        chk("R5 tag", {30'd0, s_tag}, {30'd0, ch});
                        chk("R7 switch rst", {31'd0, s_rst}, 32'd1);
                        chk("R6 next", {30'd0, s_sel}, {30'd0, next_en(VECS[vi].mask, ch)});
                    end
                end
                ch = next_en(VECS[vi].mask, ch);
            end
        end

        // R8 single channel pass-through
        restart(2'b00, 8'd0, 4'b0100);
        pulse(24'h1); pulse(24'h2); pulse(24'h3);
        chk("R8", {31'd0, s_vld}, 32'd1);
        chk("R8", {31'd0, s_rst}, 32'd0);
        for (int k = 0; k < 2; k++) begin
            pulse(24'hA0 + 24'(k));
            chk("R8", {31'd0, s_vld}, 32'd1);
            chk("R8", {8'd0, s_res}, {8'd0, 24'hA0 + 24'(k)});
            chk("R8", {30'd0, s_sel}, 32'd2);
            chk("R8", {31'd0, s_rst}, 32'd0);
        end

        // R9 mode change during settling has no effect on that channel
        restart(2'b00, 8'd0, 4'b0011);
        pulse(24'h11);
        mode = 2'b01;
        pulse(24'h12);
        chk("R9", {31'd0, s_vld}, 32'd0);
        pulse(24'h13);
        chk("R9", {31'd0, s_vld}, 32'd1);
        chk("R9", {30'd0, s_sel}, 32'd1);
        for (int k = 1; k <= 5; k++) begin
            pulse(24'h20 + 24'(k));
            chk("R9", {31'd0, s_vld}, (k == 5) ? 32'd1 : 32'd0);
        end

        // R10 selected channel withdrawn mid-settle
        restart(2'b00, 8'd0, 4'b0011);
        pulse(24'h31);
        mask = 4'b0010;
        @(negedge clk);
        chk("R10", {30'd0, sel}, 32'd1);
        chk("R10", {31'd0, frst}, 32'd1);
        chk("R10", {31'd0, vld}, 32'd0);
        @(negedge clk);
        pulse(24'h32);
        chk("R10", {31'd0, s_vld}, 32'd0);
        pulse(24'h33);
        chk("R10", {31'd0, s_vld}, 32'd0);
        pulse(24'h34);
        chk("R10", {31'd0, s_vld}, 32'd1);
        chk("R10", {30'd0, s_tag}, 32'd1);

        // R7 data-ready inside the reset cycle is not counted
        mask = '0;
        @(negedge clk);
        mode = 2'b00; mask = 4'b0011;
        @(negedge clk);
        chk("R7", {31'd0, frst}, 32'd1);
        drdy = 1'b1; data = 24'h40;
        @(negedge clk);
        drdy = 1'b0;
        chk("R7", {31'd0, vld}, 32'd0);
        pulse(24'h41);
        pulse(24'h42);
        chk("R7 rst-cycle ignored", {31'd0, s_vld}, 32'd0);
        pulse(24'h43);
        chk("R7", {31'd0, s_vld}, 32'd1);

        // R2 mask cleared mid-scan
        mask = '0;
        @(negedge clk);
        pulse(24'h50);
        chk("R2", {31'd0, s_vld}, 32'd0);
        chk("R2", {31'd0, s_rst}, 32'd1);
        pulse(24'h51);
        chk("R2", {31'd0, s_vld}, 32'd0);
        chk("R2", {31'd0, frst}, 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule